// File: doc/BRIEF.md
# Six-Tap Half-Pixel Interpolation Filter

This block is a streaming FIR stage that turns a line of integer-position pixels into half-pixel samples, for use by a sub-pixel motion search. One pixel is accepted per cycle. Pixels move through a short shift register whose six entries are all visible at once. A fixed arithmetic unit combines those entries directly. Each result therefore costs one new pixel, and the other five window entries are reused.

The kernel weights are 1, -5, 20, 20, -5, 1, built only from shifts and adds. The signed sum is rounded, scaled down by 32 and limited to the 8-bit pixel range. The block has no notion of direction. Feeding it a row gives horizontal half-pel samples, and feeding it a column gives vertical ones. A line-start input empties the window at each row or column boundary, so no sample mixes two lines.

Top module: `hpel_fir6`

## Requirements
- R1: With window pixels p0 (oldest) to p5 (newest), the raw sum is p0 - 5*p1 + 20*p2 + 20*p3 - 5*p4 + p5, computed in signed arithmetic at least 15 bits wide.
- R2: The sample is floor((raw + 16) / 32). A raw value of 16 gives 1 and a raw value of 15 gives 0.
- R3: The sample is clamped to 0..255. Negative results give 0 and results above 255 give 255.
- R4: `smp_valid_o` stays low until six valid pixels have been taken since the last reset or line start. The first five pixels of a line produce no sample.
- R5: Once the window is full, every further valid pixel produces exactly one sample, and back-to-back pixels give back-to-back samples.
- R6: A pixel taken at clock edge E yields its dependent sample, with `smp_valid_o` high, right after edge E+1. The latency is fixed at two edges.
- R7: In a cycle with `pix_valid_i` low, the window does not shift and no sample is produced. While `smp_valid_o` is low, `smp_o` keeps its last value.
- R8: `line_start_i` empties the window. If `pix_valid_i` is high in the same cycle, that pixel becomes the first pixel of the new line. A pixel sample already in flight when the flush arrives is still delivered.
- R9: While `rst` (synchronous, active high) is asserted, and right after it, `smp_valid_o` is 0, `smp_o` is 0 and the window is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start_i | input | 1 | Flush window; qualifies the same-cycle pixel as first of a line |
| pix_valid_i | input | 1 | Pixel present on `pix_i` this cycle |
| pix_i | input | 8 | Unsigned integer pixel |
| smp_valid_o | output | 1 | Half-pixel sample valid |
| smp_o | output | 8 | Rounded, clipped half-pixel sample |

## Verification
The bench aims at the arithmetic edges. These include a rounding tie that only a correct +16 offset lifts to 1, and sums far above 255 and below zero that expose a missing clamp or a logical shift used in place of an arithmetic one. The sums near the clip limits and the signed sum also expose a sum that is too narrow or has a dropped sign. The bench also covers the window fill: a sample on the fifth pixel, a window that shifts during bubbles, or a line start that fails to discard old pixels all produce a valid pulse in the wrong cycle or a sample mixing two lines. A continuous stream with bubbles and a mid-line flush checks that the latency is exactly two edges and that the output holds between pulses.

// File: rtl/hpel_pkg.sv
package hpel_pkg;

    localparam int PIX_W  = 8;
    localparam int NTAPS  = 6;
    localparam int SUM_W  = 15;
    localparam int RND_SH = 5;

    localparam int NPAIR  = NTAPS / 2;
    localparam int CNT_W  = $clog2(NTAPS + 1);

    typedef logic [PIX_W-1:0]        pix_t;
    typedef logic signed [SUM_W-1:0] sum_t;
    typedef logic [NTAPS-1:0][PIX_W-1:0] win_t;

    typedef struct packed {
        logic vld;
        sum_t sum;
    } acc_t;

    localparam logic signed [SUM_W:0] RND_ADD = (SUM_W+1)'(1 << (RND_SH - 1));
    localparam logic signed [SUM_W:0] PIX_MAX = (SUM_W+1)'((1 << PIX_W) - 1);

    // Round to nearest (ties up), scale by 2^RND_SH, clamp into pixel range.
    function automatic pix_t round_clip(input sum_t s);
        logic signed [SUM_W:0] r;
        logic signed [SUM_W:0] q;
        r = s;
        r = r + RND_ADD;
        q = r >>> RND_SH;
        if (q[SUM_W])
            return '0;
        else if (q > PIX_MAX)
            return '1;
        else
            return q[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/hpel_window.sv
module hpel_window
    import hpel_pkg::*;
#(
    parameter int W = PIX_W,
    parameter int N = NTAPS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shift_i,
    input  logic                flush_i,
    input  logic [W-1:0]        pix_i,
    output logic [N-1:0][W-1:0] taps_o,
    output logic                full_o
);

    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] FILL = CW'(N);

    logic [N-1:0][W-1:0] taps_q;
    logic [CW-1:0]       cnt_q;
    logic [CW-1:0]       cnt_base;
    logic [CW-1:0]       cnt_nx;
    logic                full_q;

    always_comb begin
        cnt_base = flush_i ? '0 : cnt_q;
        cnt_nx   = cnt_base;
        if (shift_i && (cnt_base != FILL))
            cnt_nx = cnt_base + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nx;
            full_q <= shift_i && (cnt_nx == FILL);
        end
    end

    // Entry 0 holds the newest pixel; entry N-1 the oldest.
    for (genvar k = 0; k < N; k++) begin : g_tap
        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)
                    taps_q[k] <= '0;
                else if (flush_i)
                    taps_q[k] <= shift_i ? pix_i : '0;
                else if (shift_i)
                    taps_q[k] <= pix_i;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst || flush_i)
                    taps_q[k] <= '0;
                else if (shift_i)
                    taps_q[k] <= taps_q[k-1];
            end
        end
    end

    assign taps_o = taps_q;
    assign full_o = full_q;

endmodule

// File: rtl/hpel_kernel.sv
module hpel_kernel
    import hpel_pkg::*;
(
    input  win_t taps_i,
    output sum_t sum_o
);

    logic [NPAIR-1:0][PIX_W:0] pair;
    sum_t                      term [NPAIR];

    // Symmetric kernel: fold mirrored taps first, then weight each fold.
    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        sum_t ext;
        assign pair[i] = {1'b0, taps_i[i]} + {1'b0, taps_i[NTAPS-1-i]};
        assign ext     = sum_t'(pair[i]);
        if (i == 0) begin : g_w1
            assign term[i] = ext;
        end else if (i == 1) begin : g_w5
            assign term[i] = -((ext <<< 2) + ext);
        end else if (i == 2) begin : g_w20
            assign term[i] = (ext <<< 4) + (ext <<< 2);
        end else begin : g_w0
            assign term[i] = '0;
        end
    end

    always_comb begin
        sum_o = '0;
        for (int k = 0; k < NPAIR; k++)
            sum_o = sum_o + term[k];
    end

endmodule

// File: rtl/hpel_rndclip.sv
module hpel_rndclip
    import hpel_pkg::*;
(
    input  sum_t sum_i,
    output pix_t pix_o
);

    assign pix_o = round_clip(sum_i);

endmodule

// File: rtl/hpel_fir6.sv
module hpel_fir6
    import hpel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             line_start_i,
    input  logic             pix_valid_i,
    input  logic [PIX_W-1:0] pix_i,
    output logic             smp_valid_o,
    output logic [PIX_W-1:0] smp_o
);

    win_t taps;
    logic win_full;
    sum_t raw_sum;
    acc_t acc_q;

    hpel_window #(.W(PIX_W), .N(NTAPS)) u_win (
        .clk     (clk),
        .rst     (rst),
        .shift_i (pix_valid_i),
        .flush_i (line_start_i),
        .pix_i   (pix_i),
        .taps_o  (taps),
        .full_o  (win_full)
    );

    hpel_kernel u_mac (
        .taps_i (taps),
        .sum_o  (raw_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (win_full) begin
            acc_q.vld <= 1'b1;
            acc_q.sum <= raw_sum;
        end else begin
            acc_q.vld <= 1'b0;
        end
    end

    hpel_rndclip u_rc (
        .sum_i (acc_q.sum),
        .pix_o (smp_o)
    );

    assign smp_valid_o = acc_q.vld;

endmodule

// File: rtl/hpel_fir6_chk.sv
module hpel_fir6_chk
    import hpel_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             line_start_i,
    input logic             pix_valid_i,
    input logic [PIX_W-1:0] smp_o,
    input logic             smp_valid_o
);

    localparam logic [CNT_W-1:0] FILL = CNT_W'(NTAPS);

    logic [CNT_W-1:0] m_cnt;
    logic [CNT_W-1:0] m_base;
    logic [CNT_W-1:0] m_nx;
    logic             m_d1;
    logic             m_d2;

    always_comb begin
        m_base = line_start_i ? '0 : m_cnt;
        m_nx   = (pix_valid_i && m_base != FILL) ? m_base + CNT_W'(1) : m_base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_cnt <= '0;
            m_d1  <= 1'b0;
            m_d2  <= 1'b0;
        end else begin
            m_cnt <= m_nx;
            m_d1  <= pix_valid_i && (m_nx == FILL);
            m_d2  <= m_d1;
        end
    end

    // R4
    fill_gate_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid_o == m_d2);

    // R6
    two_edge_latency_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid_o |-> $past(pix_valid_i, 2));

    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid_o |-> $stable(smp_o));

    // R8
    flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        line_start_i |=> ##1 (!smp_valid_o ##1 !smp_valid_o));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!smp_valid_o && smp_o == '0));

endmodule

bind hpel_fir6 hpel_fir6_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .line_start_i (line_start_i),
    .pix_valid_i  (pix_valid_i),
    .smp_o        (smp_o),
    .smp_valid_o  (smp_valid_o)
);

// File: tb/hpel_fir6_bench.sv
module hpel_fir6_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_start = 1'b0;
    logic       pix_valid = 1'b0;
    logic [7:0] pix = 8'd0;
    logic       smp_valid;
    logic [7:0] smp;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    always #5ns clk = ~clk;

    hpel_fir6 u_hpel_fir6 (
        .clk          (clk),
        .rst          (rst),
        .line_start_i (line_start),
        .pix_valid_i  (pix_valid),
        .pix_i        (pix),
        .smp_valid_o  (smp_valid),
        .smp_o        (smp)
    );

    localparam int NV = 11;
    localparam logic [7:0] VPIX [NV][6] = '{
        '{8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0  },
        '{8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255},
        '{8'd0,   8'd0,   8'd255, 8'd255, 8'd0,   8'd0  },
        '{8'd255, 8'd255, 8'd0,   8'd0,   8'd255, 8'd255},
        '{8'd10,  8'd20,  8'd30,  8'd40,  8'd50,  8'd60 },
        '{8'd100, 8'd100, 8'd100, 8'd100, 8'd100, 8'd100},
        '{8'd16,  8'd0,   8'd0,   8'd0,   8'd0,   8'd0  },
        '{8'd15,  8'd0,   8'd0,   8'd0,   8'd0,   8'd0  },
        '{8'd1,   8'd2,   8'd3,   8'd4,   8'd5,   8'd6  },
        '{8'd0,   8'd255, 8'd0,   8'd0,   8'd255, 8'd0  },
        '{8'd200, 8'd50,  8'd120, 8'd90,  8'd30,  8'd7  }
    };
    localparam logic [7:0] VEXP [NV] = '{
        8'd0, 8'd255, 8'd255, 8'd0, 8'd35, 8'd100, 8'd1, 8'd0, 8'd4, 8'd0, 8'd125
    };

    // Bench model of the window and the two-edge pipeline.
    int         m_hist [6];
    int         m_cnt = 0;
    logic       ea_v = 0, eb_v = 0;
    logic [7:0] ea_d = 0, eb_d = 0;
    logic [7:0] hold = 0;

    function automatic logic [7:0] ref_smp(int p0, int p1, int p2, int p3, int p4, int p5);
        int s;
        s = p0 - 5*p1 + 20*p2 + 20*p3 - 5*p4 + p5;
        s = (s + 16) >>> 5;
        if (s < 0) s = 0;
        if (s > 255) s = 255;
        return 8'(s);
    endfunction

    task automatic check(input string tag, input logic ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: compare outputs with the model, then apply new inputs.
    task automatic step(input string tag, input logic ls, input logic v, input logic [7:0] p);
        @(negedge clk);
        if (eb_v) begin
            check(tag, smp_valid === 1'b1 && smp === eb_d, {smp_valid, smp}, {1'b1, eb_d});
            hold = eb_d;
        end else begin
            check(tag, smp_valid === 1'b0 && smp === hold, {smp_valid, smp}, {1'b0, hold});
        end
        eb_v = ea_v;
        eb_d = ea_d;
        ea_v = 1'b0;
        if (ls) m_cnt = 0;
        if (v) begin
            for (int k = 0; k < 5; k++) m_hist[k] = m_hist[k+1];
            m_hist[5] = int'(p);
            if (m_cnt < 6) m_cnt++;
            if (m_cnt == 6) begin
                ea_v = 1'b1;
                ea_d = ref_smp(m_hist[0], m_hist[1], m_hist[2], m_hist[3], m_hist[4], m_hist[5]);
            end
        end
        line_start = ls;
        pix_valid  = v;
        pix        = p;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; line_start = 0; pix_valid = 0; pix = 0;
        @(negedge clk);
        @(negedge clk);
        // R9: outputs cleared while reset is held
        check("R9", smp_valid === 1'b0 && smp === 8'd0, {smp_valid, smp}, 0);
        rst = 1'b0;
        m_cnt = 0; ea_v = 0; eb_v = 0; hold = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // Table walk: R1 arithmetic, R2 rounding ties, R3 clamping.
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < 6; i++)
                step("R1", i == 0, 1'b1, VPIX[v][i]);
            step("R6", 1'b0, 1'b0, 8'd0);
            step("R6", 1'b0, 1'b0, 8'd0);
            check("R1/R2/R3 table", smp_valid === 1'b1 && smp === VEXP[v], smp, VEXP[v]);
            step("R7", 1'b0, 1'b0, 8'd0);
        end

        // R4: the first five pixels of a line give no sample.
        for (int i = 0; i < 5; i++) step("R4", i == 0, 1'b1, 8'(40 + i));
        step("R4", 1'b0, 1'b0, 8'd0);
        step("R4", 1'b0, 1'b0, 8'd0);
        check("R4 not full", smp_valid === 1'b0, smp_valid, 0);

        // R5: continuous stream, one sample per pixel once full.
        for (int i = 0; i < 16; i++) step("R5", i == 0, 1'b1, 8'((i * 37 + 11) % 256));
        step("R5", 1'b0, 1'b0, 8'd0);
        step("R5", 1'b0, 1'b0, 8'd0);

        // R7: bubbles between pixels do not shift the window; output holds.
        for (int i = 0; i < 20; i++)
            step("R7", i == 0, (i % 3) != 1, 8'((i * 53 + 7) % 256));
        step("R7", 1'b0, 1'b0, 8'd0);
        step("R7", 1'b0, 1'b0, 8'd0);

        // R8: mid-line flush, with and without a pixel in the same cycle.
        for (int i = 0; i < 8; i++) step("R8", i == 0, 1'b1, 8'(200 - i * 9));
        for (int i = 0; i < 7; i++) step("R8", i == 0, 1'b1, 8'(i * 21));
        step("R8", 1'b1, 1'b0, 8'd0);
        for (int i = 0; i < 7; i++) step("R8", 1'b0, 1'b1, 8'(250 - i * 30));
        step("R8", 1'b0, 1'b0, 8'd0);
        step("R8", 1'b0, 1'b0, 8'd0);

        // R9: reset in mid-stream empties the window.
        for (int i = 0; i < 7; i++) step("R9", i == 0, 1'b1, 8'd90);
        do_reset();
        for (int i = 0; i < 5; i++) step("R9", 1'b0, 1'b1, 8'd60);
        for (int i = 0; i < 3; i++) step("R9", 1'b0, 1'b0, 8'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule